// File: doc/BRIEF.md
# Board system control register block

This block is a small memory-mapped register file for a board's control functions. It sits on a 32-bit register bus, decodes byte offsets inside a 4 KB window and returns read data one cycle after the read access. It holds the following:

- a fixed identification word;
- an LED output register;
- two free configuration words;
- two independent flag words. Each one has its own write address that sets bits and its own write address that clears bits.
- a reset control register.

The reset control register is guarded by a lock register. A write to the reset control register takes effect only while the lock holds one exact 16-bit key. When that write carries bit 8 high, the block emits a one-cycle board-reset request pulse to the board's reset logic.

Oscillator, switch, counter and DMA-mapping offsets are not implemented. Apart from two fixed words, every unimplemented offset reads as zero, and writes to these offsets are dropped.

Top module: `brd_sysctl`

## Requirements
- R1: A read of offset 0x00 returns 0x41007004, and writes to that offset change nothing.
- R2: Offset 0x08 is an LED register: it reads back the last value written.
- R3: A write to the lock register at 0x20 stores 0xA05F when the written word is exactly 0x0000A05F. Any other word is stored as its low 16 bits with bit 15 forced to 0. A read returns the stored 16 bits zero-extended.
- R4: Offsets 0x28 and 0x2C are two independent configuration words that read back the last value written.
- R5: A write to 0x30 ORs the data into the primary flag word. A write to 0x34 clears the flag bits where the data is 1. Reading 0x30 returns the flag word, and reading 0x34 returns 0.
- R6: The secondary flag word works the same way, with set and readback at 0x38 and clear at 0x3C. It is independent of the primary flag word, and reading 0x3C returns 0.
- R7: A write to reset control at 0x40 is stored only while the lock register holds 0xA05F; otherwise it is dropped. A read of 0x40 returns the stored word.
- R8: An accepted write to 0x40 with data bit 8 set drives board_rst_req_o high for exactly the cycle after the write. Each such write gives its own pulse, and the stored reset control word is kept.
- R9: Offset 0x44 reads 0x00000001 and offset 0x50 reads 0x00001000. Every other unimplemented offset reads 0. Writes to any of these offsets change nothing.
- R10: After reset, the lock holds 0 (locked), and the LED, configuration, both flag and reset control registers are 0. rdata_o and board_rst_req_o are also 0.
- R11: rdata_o is loaded on the clock edge of a read access (sel_i=1, we_i=0) and holds its value in every other cycle, including during writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset in the window; bits 1:0 ignored |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read access |
| board_rst_req_o | output | 1 | One-cycle board-reset request |

## Verification
The lock register holds its state silently, so an error in it shows only at the ports. A wrong lock shows up on the next write to reset control: the write is either dropped or accepted when it should not be. The error becomes visible one cycle later, both as a missing or extra pulse and in the readback of 0x40. A flag word that loses or gains bits can be seen on the first read of its set address after the faulty write. Because reads are registered, every fault in stored state appears exactly one cycle after the read access that exposes it.

// File: rtl/brd_sysctl_pkg.sv
package brd_sysctl_pkg;

  localparam int unsigned WIN_AW   = 12;
  localparam int unsigned LOCK_W   = 16;
  localparam int unsigned LOCK_TOP = 15;
  localparam int unsigned RST_BIT  = 8;
  localparam int unsigned N_CFG    = 2;
  localparam int unsigned N_FLAG   = 2;

  localparam logic [31:0]       ID_WORD   = 32'h4100_7004;
  localparam logic [31:0]       PCI_WORD  = 32'h0000_0001;
  localparam logic [31:0]       CLCD_WORD = 32'h0000_1000;
  localparam logic [LOCK_W-1:0] LOCK_KEY  = 16'hA05F;

  localparam logic [WIN_AW-1:0] OFS_ID     = 12'h000;
  localparam logic [WIN_AW-1:0] OFS_LED    = 12'h008;
  localparam logic [WIN_AW-1:0] OFS_LOCK   = 12'h020;
  localparam logic [WIN_AW-1:0] OFS_CFG0   = 12'h028;
  localparam logic [WIN_AW-1:0] OFS_CFG1   = 12'h02C;
  localparam logic [WIN_AW-1:0] OFS_FLGSET = 12'h030;
  localparam logic [WIN_AW-1:0] OFS_FLGCLR = 12'h034;
  localparam logic [WIN_AW-1:0] OFS_NVSET  = 12'h038;
  localparam logic [WIN_AW-1:0] OFS_NVCLR  = 12'h03C;
  localparam logic [WIN_AW-1:0] OFS_RSTCTL = 12'h040;
  localparam logic [WIN_AW-1:0] OFS_PCI    = 12'h044;
  localparam logic [WIN_AW-1:0] OFS_CLCD   = 12'h050;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ID,
    SEL_LED,
    SEL_LOCK,
    SEL_CFG0,
    SEL_CFG1,
    SEL_FLGSET,
    SEL_FLGCLR,
    SEL_NVSET,
    SEL_NVCLR,
    SEL_RSTCTL,
    SEL_PCI,
    SEL_CLCD
  } reg_sel_e;

endpackage

// File: rtl/brd_sysctl_decode.sv
module brd_sysctl_decode
  import brd_sysctl_pkg::*;
#(
  parameter int unsigned AW = WIN_AW
) (
  input  logic [AW-1:0] addr_i,
  output reg_sel_e      sel_o
);

  localparam int unsigned WAW = AW - 2;

  logic [WAW-1:0] widx;
  assign widx = addr_i[AW-1:2];

  always_comb begin
    sel_o = SEL_NONE;
    if      (widx == WAW'(OFS_ID     >> 2)) sel_o = SEL_ID;
    else if (widx == WAW'(OFS_LED    >> 2)) sel_o = SEL_LED;
    else if (widx == WAW'(OFS_LOCK   >> 2)) sel_o = SEL_LOCK;
    else if (widx == WAW'(OFS_CFG0   >> 2)) sel_o = SEL_CFG0;
    else if (widx == WAW'(OFS_CFG1   >> 2)) sel_o = SEL_CFG1;
    else if (widx == WAW'(OFS_FLGSET >> 2)) sel_o = SEL_FLGSET;
    else if (widx == WAW'(OFS_FLGCLR >> 2)) sel_o = SEL_FLGCLR;
    else if (widx == WAW'(OFS_NVSET  >> 2)) sel_o = SEL_NVSET;
    else if (widx == WAW'(OFS_NVCLR  >> 2)) sel_o = SEL_NVCLR;
    else if (widx == WAW'(OFS_RSTCTL >> 2)) sel_o = SEL_RSTCTL;
    else if (widx == WAW'(OFS_PCI    >> 2)) sel_o = SEL_PCI;
    else if (widx == WAW'(OFS_CLCD   >> 2)) sel_o = SEL_CLCD;
  end

endmodule

// File: rtl/brd_sysctl_setclr.sv
module brd_sysctl_setclr #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] q_o
);

  logic [DW-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (set_i) q_q <= q_q | data_i;
    else if (clr_i) q_q <= q_q & ~data_i;
  end

  assign q_o = q_q;

  // R5 and R6 share this cell
  assert_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> ((q_o & $past(data_i)) == $past(data_i)));
  assert_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> ((q_o & $past(data_i)) == '0));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/brd_sysctl_guard.sv
module brd_sysctl_guard
  import brd_sysctl_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_we_i,
  input  logic              rst_we_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [LOCK_W-1:0] lock_o,
  output logic [DW-1:0]     rstctl_o,
  output logic              rst_req_o
);

  logic [LOCK_W-1:0] lock_q, lock_nxt;
  logic [DW-1:0]     rstctl_q;
  logic              req_q;
  logic              unlocked;

  assign unlocked = (lock_q == LOCK_KEY);

  always_comb begin
    lock_nxt = wdata_i[LOCK_W-1:0];
    if (wdata_i != DW'(LOCK_KEY)) lock_nxt[LOCK_TOP] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q   <= '0;
      rstctl_q <= '0;
      req_q    <= 1'b0;
    end else begin
      if (lock_we_i) lock_q <= lock_nxt;
      if (rst_we_i && unlocked) rstctl_q <= wdata_i;
      req_q <= rst_we_i && unlocked && wdata_i[RST_BIT];
    end
  end

  assign lock_o    = lock_q;
  assign rstctl_o  = rstctl_q;
  assign rst_req_o = req_q;

  // only the exact key can leave the top lock bit set
  assert_key_only_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o[LOCK_TOP] |-> (lock_o == LOCK_KEY));
  assert_locked_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o != LOCK_KEY) |=> $stable(rstctl_o));
  assert_pulse_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_we_i && (lock_o == LOCK_KEY) && wdata_i[RST_BIT]) |=> rst_req_o);
  assert_pulse_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> $past(rst_we_i && wdata_i[RST_BIT]));
  assert_pulse_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (rstctl_o[RST_BIT] == 1'b1));

endmodule

// File: rtl/brd_sysctl.sv
module brd_sysctl
  import brd_sysctl_pkg::*;
#(
  parameter int unsigned AW = WIN_AW,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          board_rst_req_o
);

  reg_sel_e          rsel;
  logic              wr, rd;
  logic [DW-1:0]     led_q;
  logic [DW-1:0]     cfg_q  [N_CFG];
  logic [DW-1:0]     flag_q [N_FLAG];
  logic [LOCK_W-1:0] lock_w;
  logic [DW-1:0]     rstctl_w;
  logic [DW-1:0]     rd_mux;
  logic [DW-1:0]     rdata_q;

  assign wr = sel_i & we_i;
  assign rd = sel_i & ~we_i;

  brd_sysctl_decode #(.AW(AW)) u_decode (
    .addr_i (addr_i),
    .sel_o  (rsel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    led_q <= '0;
    else if (wr && rsel == SEL_LED) led_q <= wdata_i;
  end

  for (genvar i = 0; i < N_CFG; i++) begin : g_cfg
    localparam reg_sel_e CODE = (i == 0) ? SEL_CFG0 : SEL_CFG1;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cfg_q[i] <= '0;
      else if (wr && rsel == CODE) cfg_q[i] <= wdata_i;
    end
  end

  // index 0: primary flags (R5), index 1: secondary flags (R6)
  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    localparam reg_sel_e SET_CODE = (i == 0) ? SEL_FLGSET : SEL_NVSET;
    localparam reg_sel_e CLR_CODE = (i == 0) ? SEL_FLGCLR : SEL_NVCLR;
    brd_sysctl_setclr #(.DW(DW)) u_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wr && rsel == SET_CODE),
      .clr_i  (wr && rsel == CLR_CODE),
      .data_i (wdata_i),
      .q_o    (flag_q[i])
    );
  end

  brd_sysctl_guard #(.DW(DW)) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_we_i (wr && rsel == SEL_LOCK),
    .rst_we_i  (wr && rsel == SEL_RSTCTL),
    .wdata_i   (wdata_i),
    .lock_o    (lock_w),
    .rstctl_o  (rstctl_w),
    .rst_req_o (board_rst_req_o)
  );

  always_comb begin
    case (rsel)
      SEL_ID:     rd_mux = DW'(ID_WORD);
      SEL_LED:    rd_mux = led_q;
      SEL_LOCK:   rd_mux = DW'(lock_w);
      SEL_CFG0:   rd_mux = cfg_q[0];
      SEL_CFG1:   rd_mux = cfg_q[1];
      SEL_FLGSET: rd_mux = flag_q[0];
      SEL_NVSET:  rd_mux = flag_q[1];
      SEL_RSTCTL: rd_mux = rstctl_w;
      SEL_PCI:    rd_mux = DW'(PCI_WORD);
      SEL_CLCD:   rd_mux = DW'(CLCD_WORD);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  assert_id_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i[AW-1:2] == '0) |=> (rdata_o == DW'(ID_WORD)));
  assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
  assert_led_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && rsel == SEL_LED) |=> (led_q == $past(wdata_i)));

endmodule

// File: tb/brd_sysctl_bench.sv
module brd_sysctl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rst_req;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic last_pulse;

  always #2 clk = ~clk;

  brd_sysctl u_brd_sysctl (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .sel_i           (sel),
    .we_i            (we),
    .addr_i          (addr),
    .wdata_i         (wdata),
    .rdata_o         (rdata),
    .board_rst_req_o (rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    last_pulse = rst_req;
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset;
    check("R10 rdata", rdata, 32'h0);
    check("R10 pulse", {31'h0, rst_req}, 32'h0);
    rd_chk("R10 led",   12'h008, 32'h0);
    rd_chk("R10 lock",  12'h020, 32'h0);
    rd_chk("R10 cfg0",  12'h028, 32'h0);
    rd_chk("R10 cfg1",  12'h02C, 32'h0);
    rd_chk("R10 flags", 12'h030, 32'h0);
    rd_chk("R10 nv",    12'h038, 32'h0);
    rd_chk("R10 rstctl",12'h040, 32'h0);
  endtask

  task automatic t_id;
    rd_chk("R1 id", 12'h000, 32'h4100_7004);
    wr(12'h000, 32'hFFFF_FFFF);
    rd_chk("R1 id after write", 12'h000, 32'h4100_7004);
    rd_chk("R1 id low bits ignored", 12'h003, 32'h4100_7004);
  endtask

  task automatic t_led;
    wr(12'h008, 32'hDEAD_BEEF);
    rd_chk("R2 led", 12'h008, 32'hDEAD_BEEF);
    wr(12'h008, 32'h0000_0005);
    rd_chk("R2 led rewrite", 12'h008, 32'h0000_0005);
  endtask

  task automatic t_cfg;
    wr(12'h028, 32'h1234_5678);
    wr(12'h02C, 32'hCAFE_F00D);
    rd_chk("R4 cfg0", 12'h028, 32'h1234_5678);
    rd_chk("R4 cfg1", 12'h02C, 32'hCAFE_F00D);
  endtask

  task automatic t_flags;
    wr(12'h030, 32'h0000_F0F0);
    wr(12'h030, 32'h0000_000F);
    rd_chk("R5 set or", 12'h030, 32'h0000_F0FF);
    wr(12'h034, 32'h0000_00F0);
    rd_chk("R5 clear", 12'h030, 32'h0000_F00F);
    rd_chk("R5 clr reads zero", 12'h034, 32'h0);
    rd_chk("R6 nv untouched", 12'h038, 32'h0);
  endtask

  task automatic t_nv;
    wr(12'h038, 32'h8000_0001);
    wr(12'h038, 32'h0100_0000);
    rd_chk("R6 nv set", 12'h038, 32'h8100_0001);
    wr(12'h03C, 32'h8000_0000);
    rd_chk("R6 nv clear", 12'h038, 32'h0100_0001);
    rd_chk("R6 nv clr reads zero", 12'h03C, 32'h0);
    rd_chk("R5 flags untouched", 12'h030, 32'h0000_F00F);
  endtask

  task automatic t_lock;
    wr(12'h020, 32'h0000_FFFF);
    rd_chk("R3 bit15 forced", 12'h020, 32'h0000_7FFF);
    wr(12'h020, 32'h0001_A05F);
    rd_chk("R3 near key", 12'h020, 32'h0000_205F);
    wr(12'h020, 32'h0000_A05F);
    rd_chk("R3 key", 12'h020, 32'h0000_A05F);
    wr(12'h020, 32'h0000_0000);
    rd_chk("R3 relock", 12'h020, 32'h0);
  endtask

  task automatic t_rstctl;
    wr(12'h040, 32'h0000_01FF);
    check("R7 locked no pulse", {31'h0, last_pulse}, 32'h0);
    rd_chk("R7 locked dropped", 12'h040, 32'h0);
    wr(12'h020, 32'h0000_205F);
    wr(12'h040, 32'h0000_01FF);
    check("R7 wrong key no pulse", {31'h0, last_pulse}, 32'h0);
    rd_chk("R7 wrong key dropped", 12'h040, 32'h0);
    wr(12'h020, 32'h0000_A05F);
    wr(12'h040, 32'h0000_00FF);
    check("R8 bit8 clear no pulse", {31'h0, last_pulse}, 32'h0);
    rd_chk("R7 unlocked stored", 12'h040, 32'h0000_00FF);
    wr(12'h040, 32'h0000_0101);
    check("R8 pulse high", {31'h0, last_pulse}, 32'h1);
    @(negedge clk);
    check("R8 pulse one cycle", {31'h0, rst_req}, 32'h0);
    rd_chk("R8 value kept", 12'h040, 32'h0000_0101);
    wr(12'h040, 32'h0000_0100);
    check("R8 second pulse", {31'h0, last_pulse}, 32'h1);
    wr(12'h020, 32'h0);
    wr(12'h040, 32'h0);
    rd_chk("R7 relocked dropped", 12'h040, 32'h0000_0100);
  endtask

  task automatic t_fixed;
    rd_chk("R9 pci word", 12'h044, 32'h0000_0001);
    rd_chk("R9 clcd word", 12'h050, 32'h0000_1000);
    wr(12'h050, 32'hFFFF_FFFF);
    rd_chk("R9 clcd write ignored", 12'h050, 32'h0000_1000);
    wr(12'h00C, 32'hFFFF_FFFF);
    rd_chk("R9 osc reads zero", 12'h00C, 32'h0);
    rd_chk("R9 top of window", 12'hFFC, 32'h0);
    rd_chk("R9 led unaffected", 12'h008, 32'h0000_0005);
  endtask

  task automatic t_hold;
    rd_chk("R11 load", 12'h000, 32'h4100_7004);
    repeat (3) @(negedge clk);
    check("R11 idle hold", rdata, 32'h4100_7004);
    wr(12'h008, 32'h0000_0077);
    check("R11 write hold", rdata, 32'h4100_7004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_id();
    t_led();
    t_cfg();
    t_flags();
    t_nv();
    t_lock();
    t_rstctl();
    t_fixed();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule